// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single shared interrupt wire that runs on the PCI clock. The host and any number of peripherals share the line through open-drain style drivers and a weak pull-up. The block runs a repeating frame cycle. It first sends a start frame. It then leaves the line free for a fixed run of three-clock data slots, one slot per interrupt source, during which peripherals report their request levels. It then sends a stop frame. The stop frame's length tells the peripherals whether the next cycle is started by the host or by a peripheral. The levels sampled in one cycle are collected in a shadow register. They reach the parallel output together, once the stop frame is over, so a downstream interrupt controller never sees a half-updated set.

An agent never lets the line float straight up from low. Every clock that the host drives low is followed by exactly one clock driven high, and then the line is released. In continuous operation the host starts each cycle at once after the previous one ends. In quiet operation the host waits with the line released. A peripheral that needs service pulls the line low for one clock, and the host extends that low to the full start width. After reset the block always runs one host-started cycle, so that the current level of every source is gathered.

Top module: `sirq_host`

## Requirements
- R1: While reset is held and after it is released, `irq_o` is all zero. The first clock after reset drives the line low (`drv_oe_o`=1, `drv_val_o`=0) as the start of a host-started cycle.
- R2: A host-started start frame drives the line low for 4, 6, 8 or 8 clocks for `start_width_i` = 0, 1, 2 or 3. It then drives the line high for one clock and releases it for one clock. The width is the value of `start_width_i` at the clock edge that begins the frame.
- R3: After the start frame come 21 data slots of 3 clocks each. The host keeps `drv_oe_o` at 0 for all 63 clocks, and slot k is sampled on its first clock.
- R4: A low sample in slot k sets `irq_o[k]`, and a high sample clears it. Slot order: bit 0 IRQ0, bit 1 IRQ1, bit 2 SMI#, bits 3..15 IRQ3..IRQ15, bit 16 IOCHK#, bits 17..20 INTA#..INTD#.
- R5: `irq_o` changes only on the clock edge that ends the stop frame's released clock, and all bits change on that same edge.
- R6: The stop frame drives the line low for 2 clocks if `mode_quiet_i` is 1, or for 3 clocks if it is 0. It then drives high for one clock and releases for one clock. The mode is the value of `mode_quiet_i` at the edge that ends the last data slot.
- R7: After a stop frame that selects continuous operation, the next host start frame begins on the very next clock.
- R8: After a stop frame that selects quiet operation, the host keeps the line released, and `irq_o` holds, until `line_i` is sampled low. Changes on the sources have no effect during that time. On the edge where a low is sampled, the host drives the line low for the width minus one further clocks, so the low lasts the full start width in total.
- R9: Every run of host-driven low clocks ends with exactly one host-driven high clock, and the clock after any host-driven high clock is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock; all activity on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_quiet_i | input | 1 | 1 selects quiet operation for the next cycle, 0 selects continuous |
| start_width_i | input | 2 | Start frame low width code: 0=4, 1=6, 2 or 3=8 clocks |
| line_i | input | 1 | Sampled level of the shared wire |
| drv_oe_o | output | 1 | 1 while the host drives the wire |
| drv_val_o | output | 1 | Level driven when `drv_oe_o` is 1 |
| irq_o | output | 21 | Decoded request levels, 1 = asserted, bit k = slot k |

## Verification
The source patterns pick out specific slots: SMI# alone with IRQ0, IOCHK# with SMI#, the four PCI lines, all ones, and alternating bits. A slot that is off by one or a bit order that is swapped then gives a wrong vector. Each start width code is used in both continuous and quiet cycles, so the low length, the recovery clock and the peripheral-extended start are all compared clock by clock against the model's expected line activity. The bench switches between the modes in both directions to tell 2-clock from 3-clock stop frames. While the host waits in quiet operation, the bench changes the sources and checks that neither the line nor the output moves until a peripheral pulse arrives.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    // Counter wide enough for the longest frame segment (8 clocks).
    localparam int CNT_W        = 4;
    localparam int SLOT_CLOCKS  = 3;

    // Slot positions of the control-type sources inside the vector.
    localparam int SLOT_SMI     = 2;
    localparam int SLOT_IOCHK   = 16;
    localparam int SLOT_INT_A   = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_START_REC,
        ST_START_TA,
        ST_SLOT,
        ST_STOP,
        ST_STOP_REC,
        ST_STOP_TA
    } seq_state_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    // Low width of the start frame for a width code.
    function automatic logic [CNT_W-1:0] start_low_len(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(4);
            2'd1:    return CNT_W'(6);
            default: return CNT_W'(8);
        endcase
    endfunction

    // Low width of the stop frame; it encodes the next cycle's mode.
    function automatic logic [CNT_W-1:0] stop_low_len(input logic quiet);
        return quiet ? CNT_W'(2) : CNT_W'(3);
    endfunction

endpackage

// File: rtl/sirq_sequencer.sv
module sirq_sequencer
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 21,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_quiet_i,
    input  logic [1:0]        start_width_i,
    input  logic              line_i,
    output seq_state_e        state_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              sample_o,
    output logic              commit_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0]  LAST_PH   = CNT_W'(SLOT_CLOCKS - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [1:0]        width_q;
    logic              stop_quiet_q;

    logic [CNT_W-1:0]  start_last;
    logic [CNT_W-1:0]  stop_last;

    always_comb begin
        start_last = start_low_len(width_q) - CNT_W'(1);
        stop_last  = stop_low_len(stop_quiet_q) - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_START;
            cnt_q        <= '0;
            slot_q       <= '0;
            width_q      <= start_width_i;
            stop_quiet_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    width_q <= start_width_i;
                    if (!line_i) begin
                        // A peripheral already supplied the first low clock.
                        state_q <= ST_START;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                ST_START: begin
                    if (cnt_q == start_last) begin
                        state_q <= ST_START_REC;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_START_REC: state_q <= ST_START_TA;
                ST_START_TA: begin
                    state_q <= ST_SLOT;
                    slot_q  <= '0;
                    cnt_q   <= '0;
                end
                ST_SLOT: begin
                    if (cnt_q == LAST_PH) begin
                        cnt_q <= '0;
                        if (slot_q == LAST_SLOT) begin
                            state_q      <= ST_STOP;
                            stop_quiet_q <= mode_quiet_i;
                        end else begin
                            slot_q <= slot_q + SLOT_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (cnt_q == stop_last) begin
                        state_q <= ST_STOP_REC;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_STOP_REC: state_q <= ST_STOP_TA;
                ST_STOP_TA: begin
                    width_q <= start_width_i;
                    cnt_q   <= '0;
                    state_q <= stop_quiet_q ? ST_IDLE : ST_START;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state_o  = state_q;
        slot_o   = slot_q;
        sample_o = (state_q == ST_SLOT) && (cnt_q == '0);
        commit_o = (state_q == ST_STOP_TA);
    end

endmodule

// File: rtl/sirq_pin_drive.sv
module sirq_pin_drive
    import sirq_pkg::*;
(
    input  seq_state_e state_i,
    output logic       drv_oe_o,
    output logic       drv_val_o
);

    pin_drv_t drv;

    always_comb begin
        case (state_i)
            ST_START, ST_STOP:         drv = '{oe: 1'b1, val: 1'b0};
            ST_START_REC, ST_STOP_REC: drv = '{oe: 1'b1, val: 1'b1};
            default:                   drv = '{oe: 1'b0, val: 1'b1};
        endcase
        drv_oe_o  = drv.oe;
        drv_val_o = drv.val;
    end

endmodule

// File: rtl/sirq_slot_capture.sv
module sirq_slot_capture #(
    parameter int NUM_SLOTS = 21,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic                 line_i,
    input  logic                 commit_i,
    output logic [NUM_SLOTS-1:0] irq_o
);

    logic [NUM_SLOTS-1:0] shadow_q;
    logic [NUM_SLOTS-1:0] irq_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= 1'b0;
            end else if (sample_i && (slot_i == SLOT_W'(g))) begin
                shadow_q[g] <= ~line_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else if (commit_i) begin
            irq_q <= shadow_q;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 21
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_quiet_i,
    input  logic [1:0]           start_width_i,
    input  logic                 line_i,
    output logic                 drv_oe_o,
    output logic                 drv_val_o,
    output logic [NUM_SLOTS-1:0] irq_o
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);

    seq_state_e        state_w;
    logic [SLOT_W-1:0] slot_w;
    logic              sample_w;
    logic              commit_w;

    sirq_sequencer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .mode_quiet_i  (mode_quiet_i),
        .start_width_i (start_width_i),
        .line_i        (line_i),
        .state_o       (state_w),
        .slot_o        (slot_w),
        .sample_o      (sample_w),
        .commit_o      (commit_w)
    );

    sirq_pin_drive u_pin (
        .state_i   (state_w),
        .drv_oe_o  (drv_oe_o),
        .drv_val_o (drv_val_o)
    );

    sirq_slot_capture #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_w),
        .slot_i   (slot_w),
        .line_i   (line_i),
        .commit_i (commit_w),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/sirq_host_checker.sv
module sirq_host_checker
    import sirq_pkg::*;
#(
    parameter int NUM_SLOTS = 21
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 drv_oe,
    input logic                 drv_val,
    input logic [NUM_SLOTS-1:0] irq,
    input seq_state_e           state,
    input logic                 sample,
    input logic                 commit
);

    logic [3:0] low_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q <= 4'd0;
        end else if (drv_oe && !drv_val) begin
            if (low_run_q != 4'hF) low_run_q <= low_run_q + 4'd1;
        end else begin
            low_run_q <= 4'd0;
        end
    end

    AST_LOW_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        low_run_q <= 4'd8);  // R2

    AST_SLOTS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT) |-> !drv_oe);  // R3

    AST_SAMPLE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        sample |-> !drv_oe);  // R3

    AST_IRQ_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq) |-> ($past(commit) || $past(rst)));  // R5

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !drv_oe);  // R8

    AST_LOW_ENDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($past(drv_oe && !drv_val) && !(drv_oe && !drv_val)) |-> (drv_oe && drv_val));  // R9

    AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (drv_oe && drv_val) |=> !drv_oe);  // R9

endmodule

bind sirq_host sirq_host_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .drv_oe  (drv_oe_o),
    .drv_val (drv_val_o),
    .irq     (irq_o),
    .state   (state_w),
    .sample  (sample_w),
    .commit  (commit_w)
);

// File: tb/tb_sirq_host.sv
module tb_sirq_host;

    localparam int CLK_PERIOD = 10;
    localparam int NS         = 21;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_quiet = 1'b0;
    logic [1:0]    width_code = 2'd0;
    logic [NS-1:0] src = '0;
    logic          start_req = 1'b0;
    logic          slot_low = 1'b0;
    logic          drv_oe;
    logic          drv_val;
    logic [NS-1:0] irq;
    logic          line_w;

    // Wire with weak pull-up: host drive wins, otherwise any peripheral low.
    assign line_w = drv_oe ? drv_val : !(slot_low || start_req);

    sirq_host dut (
        .clk           (clk),
        .rst           (rst),
        .mode_quiet_i  (mode_quiet),
        .start_width_i (width_code),
        .line_i        (line_w),
        .drv_oe_o      (drv_oe),
        .drv_val_o     (drv_val),
        .irq_o         (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: a queue of expected clocks.
    // item = tag*1000 + kind*4 + {oe,val}; kind 10+k samples slot k,
    // kind 1 ends the data slots, kind 2 ends the stop frame.
    int            mq[$];
    bit            m_quiet;
    bit [NS-1:0]   m_shadow;
    bit [NS-1:0]   exp_irq;
    int            commits = 0;
    int            checks = 0;
    int            errors = 0;
    int            cycles = 0;
    bit            done = 0;

    function automatic int blen(input logic [1:0] c);
        return (c == 2'd0) ? 4 : (c == 2'd1) ? 6 : 8;
    endfunction

    function automatic string req_name(input int tag);
        case (tag)
            2: return "R2";
            3: return "R3";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic void push_start(input int lows, input int tag);
        for (int i = 0; i < lows; i++) mq.push_back(tag*1000 + 2);
        mq.push_back(tag*1000 + 3);
        mq.push_back(tag*1000 + 0);
        for (int k = 0; k < NS; k++) begin
            mq.push_back(3000 + (10 + k)*4);
            mq.push_back(3000);
            mq.push_back(3000 + ((k == NS-1) ? 4 : 0));
        end
    endfunction

    function automatic void push_stop(input bit q);
        for (int i = 0; i < (q ? 2 : 3); i++) mq.push_back(6000 + 2);
        mq.push_back(6000 + 3);
        mq.push_back(6000 + 8);
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     req, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            push_start(blen(width_code), 2);
            exp_irq = '0;
            m_quiet = 0;
        end else if (mq.size() == 0) begin
            if (!line_w) push_start(blen(width_code) - 1, 8);
        end else begin
            int item;
            int kind;
            item = mq.pop_front();
            kind = (item % 1000) / 4;
            if (kind >= 10) m_shadow[kind-10] = !line_w;
            if (kind == 1) begin
                m_quiet = mode_quiet;
                push_stop(mode_quiet);
            end
            if (kind == 2) begin
                exp_irq = m_shadow;
                commits++;
                if (!m_quiet) push_start(blen(width_code), 7);
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (!rst && !done) begin
            int item;
            int kind;
            int pin;
            item = (mq.size() != 0) ? mq[0] : 8000;
            pin  = item % 4;
            kind = (item % 1000) / 4;
            chk(req_name(item / 1000), 32'(drv_oe), 32'(pin / 2), "drive enable");
            if (pin / 2 == 1)
                chk(req_name(item / 1000), 32'(drv_val), 32'(pin % 2), "drive level");
            chk("R5", 32'(irq), 32'(exp_irq), "irq vector");
            slot_low = (kind >= 10) && src[kind-10];
        end else begin
            slot_low = 1'b0;
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_commits(input int n);
        int target;
        target = commits + n;
        while (commits < target) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (mq.size() != 0) @(negedge clk);
    endtask

    task automatic run_cont(input logic [1:0] w, input logic [NS-1:0] pat, input string nm);
        @(negedge clk);
        width_code = w;
        src = pat;
        wait_commits(2);
        chk("R4", 32'(irq), 32'(pat), nm);
        chk("R7", 32'({drv_oe, drv_val}), 32'd2, "restart after continuous stop");
    endtask

    task automatic quiet_cycle(input logic [1:0] w, input logic [NS-1:0] pat, input string nm);
        logic [NS-1:0] held;
        wait_idle();
        held = irq;
        src = pat;
        width_code = w;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            chk("R8", 32'(drv_oe), 32'd0, "idle drive enable");
            chk("R8", 32'(irq), 32'(held), "idle irq hold");
        end
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        chk("R8", 32'({drv_oe, drv_val}), 32'd2, "host extends peripheral start");
        wait_commits(1);
        chk("R4", 32'(irq), 32'(pat), nm);
        chk("R8", 32'(drv_oe), 32'd0, "released after quiet stop");
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", 32'(irq), 32'd0, "irq during reset");
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 32'(irq), 32'd0, "irq after reset");
        chk("R1", 32'({drv_oe, drv_val}), 32'd2, "start after reset");

        run_cont(2'd0, 21'h000005, "IRQ0 and SMI slot");
        run_cont(2'd1, 21'h1FFFFF, "all slots asserted");
        run_cont(2'd2, 21'h0AAAAA, "alternating slots");
        run_cont(2'd3, 21'h010004, "IOCHK and SMI slots");
        run_cont(2'd0, 21'h1E0000, "PCI slots");
        run_cont(2'd1, 21'h000000, "all slots clear");

        @(negedge clk);
        mode_quiet = 1'b1;
        quiet_cycle(2'd0, 21'h00F00F, "quiet width 4");
        quiet_cycle(2'd2, 21'h0F0F0F, "quiet width 8");
        quiet_cycle(2'd1, 21'h123456, "quiet width 6");

        wait_idle();
        mode_quiet = 1'b0;
        src = 21'h15A5A5;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        wait_commits(2);
        chk("R4", 32'(irq), 32'(21'h15A5A5), "back to continuous");
        chk("R7", 32'({drv_oe, drv_val}), 32'd2, "continuous resumes");
        repeat (20) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule